// File: doc/BRIEF.md
# Edge-Synchronized Radio Bit Serializer

This block takes the per-bit timing of a raw radio link off a small host processor. A free-running tick counter runs on a 4 MHz timebase. When the host arms the capture unit, the first level change on the incoming radio data line stores the counter value, which is exact to one tick. The same capture restarts a bit-phase counter. That counter sets the sampling instant in receive mode and the bit boundaries in transmit mode. A bit lasts 80 ticks, which gives 50 kb/s.

The host finds the start symbol itself with ordinary interrupt-driven I/O. It then pulses an align request so that the shift engine locks onto the captured phase. From then on the host only moves whole bytes. In transmit mode it writes them into a holding register, and in receive mode it reads them from a receive register. Each byte completion is marked by a strobe. Two sticky flags report a missed byte, one for each direction.

Top module: `sbs_edge_serializer`

## Requirements
- R1: A synchronous reset clears the tick counter, the bit phase, the capture flag, the capture time, both error flags, the receive-full flag and the transmit holding register, and leaves the engine idle. After reset, tx_line is 0 and tx_room is 1.
- R2: The tick counter reads 0 in the first cycle after reset and then increments once per clock, wrapping at 16 bits. After a cap_arm pulse, the first cycle in which rx_line differs from its value in the previous cycle copies the counter value of that cycle into cap_time. Either polarity of change counts. cap_valid is 1 from the next cycle on.
- R3: After a capture, further changes on rx_line leave cap_time and cap_valid unchanged until the next cap_arm. A cap_arm pulse clears cap_valid. A change that arrives in the same cycle as cap_arm is not captured.
- R4: align has an effect only while cap_valid is 1. In that case it starts the engine, clears both error flags and latches the direction from tx_mode (1 = transmit, 0 = receive). An align while cap_valid is 0 changes nothing.
- R5: In receive mode, rx_line is sampled 40 cycles after the capturing cycle and then every 80 cycles. Bits enter MSB first. The 8th sample loads rx_data, sets rx_full and raises byte_strobe for one cycle.
- R6: An rx_rd pulse clears rx_full. If a byte completes while rx_full is 1 and rx_rd is 0, overrun is set and the newer byte replaces the older one in rx_data.
- R7: tx_load is accepted only while tx_room is 1. The accepted value goes into the holding register and tx_room drops. In transmit mode, bit boundaries fall 80·k cycles after the capturing cycle. At a byte boundary the holding register is moved into the shifter and tx_room returns to 1. Each bit drives tx_line for 80 cycles, MSB first.
- R8: In transmit mode, byte_strobe pulses for one cycle at each byte boundary that ends a byte which was being sent.
- R9: If the holding register is empty at a byte boundary in transmit mode, underrun is set and tx_line is held at 0. The next boundary tries again.
- R10: A stop pulse returns the engine to idle. tx_line goes low, and no bit is sampled or sent until the next accepted align.
- R11: tx_line stays 0 whenever the engine is idle or in receive mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 4 MHz timebase clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_line | input | 1 | Received radio data, already synchronous to clk |
| cap_arm | input | 1 | Pulse: arm the edge capture and clear cap_valid |
| align | input | 1 | Pulse: lock the engine to the captured phase |
| stop | input | 1 | Pulse: return the engine to idle |
| tx_mode | input | 1 | Direction latched at align: 1 transmit, 0 receive |
| tx_data | input | 8 | Byte offered by the host for transmission |
| tx_load | input | 1 | Valid for tx_data |
| tx_room | output | 1 | Transmit holding register is empty |
| tx_line | output | 1 | Serial data toward the radio |
| rx_data | output | 8 | Last received byte |
| rx_full | output | 1 | rx_data holds an unread byte |
| rx_rd | input | 1 | Pulse: host has read rx_data |
| byte_strobe | output | 1 | One-cycle pulse when a byte completes |
| overrun | output | 1 | Sticky: a received byte replaced an unread one |
| underrun | output | 1 | Sticky: no byte was ready at a transmit byte boundary |
| cap_valid | output | 1 | cap_time holds a captured edge |
| cap_time | output | 16 | Counter value at the captured edge |

## Verification
Two cases are hard to reach from the ports.

The first is the race between re-arming and an edge. The bench drives cap_arm and an rx_line transition on the same negative edge, checks that nothing was captured, and then lets that same armed capture take the transmit phase on a later edge.

The second is phase-exact serial traffic. The bench drives receive bytes back to back without gaps. It reads only the first byte, so that the third and fourth completions overrun. For transmit, it samples tx_line at mid-bit positions counted from the cycle in which it produced the captured edge. It also leaves a byte stranded in the holding register from an align that was ignored, so that this byte becomes the first one sent.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
    typedef enum logic {
        SBS_RX = 1'b0,
        SBS_TX = 1'b1
    } sbs_dir_e;
endpackage

// File: rtl/sbs_capture.sv
module sbs_capture #(
    parameter int CNT_W     = 16,
    parameter int BIT_TICKS = 80,
    parameter int PH_W      = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_line,
    input  logic             cap_arm,
    output logic             cap_valid,
    output logic [CNT_W-1:0] cap_time,
    output logic [PH_W-1:0]  phase
);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(BIT_TICKS - 1);

    typedef struct packed {
        logic [CNT_W-1:0] tick;
        logic             prev;
        logic             armed;
        logic             valid;
        logic [CNT_W-1:0] stamp;
        logic [PH_W-1:0]  phase;
    } cap_state_t;

    cap_state_t s_q, s_d;

    always_comb begin
        s_d       = s_q;
        s_d.tick  = s_q.tick + 1'b1;
        s_d.prev  = rx_line;
        s_d.phase = (s_q.phase == PH_LAST) ? '0 : s_q.phase + 1'b1;
        if (cap_arm) begin
            s_d.armed = 1'b1;
            s_d.valid = 1'b0;
        end else if (s_q.armed && (rx_line != s_q.prev)) begin
            s_d.armed = 1'b0;
            s_d.valid = 1'b1;
            s_d.stamp = s_q.tick;
            s_d.phase = PH_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign cap_valid = s_q.valid;
    assign cap_time  = s_q.stamp;
    assign phase     = s_q.phase;

    assert_capture_needs_arm_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(s_q.valid) |-> ($past(s_q.armed) && (s_q.phase == PH_W'(1))));

    assert_stamp_held_R3: assert property (@(posedge clk) disable iff (rst)
        (s_q.valid && !cap_arm) |=> ($stable(s_q.stamp) && s_q.valid));

    assert_phase_range_R5: assert property (@(posedge clk) disable iff (rst)
        s_q.phase < PH_W'(BIT_TICKS));
endmodule

// File: rtl/sbs_shifter.sv
module sbs_shifter
    import sbs_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int BIT_TICKS = 80,
    parameter int PH_W      = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PH_W-1:0]   phase,
    input  logic              cap_valid,
    input  logic              align,
    input  logic              stop,
    input  logic              tx_mode,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_load,
    output logic              tx_room,
    output logic              tx_line,
    input  logic              rx_line,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_full,
    input  logic              rx_rd,
    output logic              byte_strobe,
    output logic              overrun,
    output logic              underrun
);
    localparam int              BC_W    = $clog2(DATA_W);
    localparam logic [BC_W-1:0] BC_LAST = BC_W'(DATA_W - 1);
    localparam logic [PH_W-1:0] PH_MID  = PH_W'(BIT_TICKS / 2);

    typedef struct packed {
        logic              active;
        sbs_dir_e          dir;
        logic [BC_W-1:0]   bitcnt;
        logic [DATA_W-1:0] shreg;
        logic              sending;
        logic              line;
        logic [DATA_W-1:0] hold;
        logic              hold_full;
        logic [DATA_W-1:0] rxd;
        logic              rxf;
        logic              ovr;
        logic              und;
        logic              strobe;
    } sh_state_t;

    sh_state_t s_q, s_d;

    always_comb begin
        s_d        = s_q;
        s_d.strobe = 1'b0;
        if (rx_rd) s_d.rxf = 1'b0;
        if (tx_load && !s_q.hold_full) begin
            s_d.hold      = tx_data;
            s_d.hold_full = 1'b1;
        end
        if (stop) begin
            s_d.active  = 1'b0;
            s_d.bitcnt  = '0;
            s_d.sending = 1'b0;
            s_d.line    = 1'b0;
        end else if (align && cap_valid) begin
            s_d.active  = 1'b1;
            s_d.dir     = tx_mode ? SBS_TX : SBS_RX;
            s_d.bitcnt  = '0;
            s_d.sending = 1'b0;
            s_d.line    = 1'b0;
            s_d.ovr     = 1'b0;
            s_d.und     = 1'b0;
        end else if (s_q.active) begin
            if ((s_q.dir == SBS_RX) && (phase == PH_MID)) begin
                s_d.shreg = {s_q.shreg[DATA_W-2:0], rx_line};
                if (s_q.bitcnt == BC_LAST) begin
                    s_d.bitcnt = '0;
                    s_d.rxd    = {s_q.shreg[DATA_W-2:0], rx_line};
                    s_d.strobe = 1'b1;
                    if (s_q.rxf && !rx_rd) s_d.ovr = 1'b1;
                    s_d.rxf = 1'b1;
                end else begin
                    s_d.bitcnt = s_q.bitcnt + 1'b1;
                end
            end
            if ((s_q.dir == SBS_TX) && (phase == '0)) begin
                if (s_q.bitcnt == '0) begin
                    if (s_q.sending) s_d.strobe = 1'b1;
                    if (s_q.hold_full) begin
                        s_d.shreg     = {s_q.hold[DATA_W-2:0], 1'b0};
                        s_d.line      = s_q.hold[DATA_W-1];
                        s_d.hold_full = 1'b0;
                        s_d.sending   = 1'b1;
                        s_d.bitcnt    = BC_W'(1);
                    end else begin
                        s_d.line    = 1'b0;
                        s_d.sending = 1'b0;
                        s_d.und     = 1'b1;
                    end
                end else begin
                    s_d.line   = s_q.shreg[DATA_W-1];
                    s_d.shreg  = {s_q.shreg[DATA_W-2:0], 1'b0};
                    s_d.bitcnt = (s_q.bitcnt == BC_LAST) ? '0 : s_q.bitcnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign tx_room     = !s_q.hold_full;
    assign tx_line     = s_q.line;
    assign rx_data     = s_q.rxd;
    assign rx_full     = s_q.rxf;
    assign byte_strobe = s_q.strobe;
    assign overrun     = s_q.ovr;
    assign underrun    = s_q.und;

    assert_rx_strobe_midbit_R5: assert property (@(posedge clk) disable iff (rst)
        (s_q.strobe && s_q.dir == SBS_RX) |-> ($past(phase) == PH_MID));

    assert_rx_full_with_strobe_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(s_q.rxf) |-> s_q.strobe);

    assert_overrun_needs_full_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(s_q.ovr) |-> ($past(s_q.rxf) && s_q.strobe));

    assert_underrun_line_low_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(s_q.und) |-> !s_q.line);

    assert_idle_line_low_R11: assert property (@(posedge clk) disable iff (rst)
        (!s_q.active || s_q.dir == SBS_RX) |-> !s_q.line);
endmodule

// File: rtl/sbs_edge_serializer.sv
module sbs_edge_serializer #(
    parameter int CNT_W     = 16,
    parameter int DATA_W    = 8,
    parameter int BIT_TICKS = 80
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_line,
    input  logic              cap_arm,
    input  logic              align,
    input  logic              stop,
    input  logic              tx_mode,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_load,
    output logic              tx_room,
    output logic              tx_line,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_full,
    input  logic              rx_rd,
    output logic              byte_strobe,
    output logic              overrun,
    output logic              underrun,
    output logic              cap_valid,
    output logic [CNT_W-1:0]  cap_time
);
    localparam int PH_W = $clog2(BIT_TICKS);

    logic [PH_W-1:0] phase;

    sbs_capture #(.CNT_W(CNT_W), .BIT_TICKS(BIT_TICKS), .PH_W(PH_W)) u_capture (
        .clk       (clk),
        .rst       (rst),
        .rx_line   (rx_line),
        .cap_arm   (cap_arm),
        .cap_valid (cap_valid),
        .cap_time  (cap_time),
        .phase     (phase)
    );

    sbs_shifter #(.DATA_W(DATA_W), .BIT_TICKS(BIT_TICKS), .PH_W(PH_W)) u_shifter (
        .clk         (clk),
        .rst         (rst),
        .phase       (phase),
        .cap_valid   (cap_valid),
        .align       (align),
        .stop        (stop),
        .tx_mode     (tx_mode),
        .tx_data     (tx_data),
        .tx_load     (tx_load),
        .tx_room     (tx_room),
        .tx_line     (tx_line),
        .rx_line     (rx_line),
        .rx_data     (rx_data),
        .rx_full     (rx_full),
        .rx_rd       (rx_rd),
        .byte_strobe (byte_strobe),
        .overrun     (overrun),
        .underrun    (underrun)
    );
endmodule

// File: tb/tb_sbs_edge_serializer.sv
`timescale 1ns/1ps
module tb_sbs_edge_serializer;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_line = 1'b0, cap_arm = 1'b0, align = 1'b0, stop = 1'b0;
    logic       tx_mode = 1'b0, tx_load = 1'b0, rx_rd = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       tx_room, tx_line, rx_full, byte_strobe, overrun, underrun, cap_valid;
    logic [7:0] rx_data;
    logic [15:0] cap_time;

    int total = 0, bad = 0, cycles = 0;
    bit run_cmp = 1'b0, done = 1'b0;
    bit seen_tx_high = 1'b0;
    int strobe_cnt = 0;

    always #5 clk = ~clk;

    sbs_edge_serializer dut (
        .clk(clk), .rst(rst), .rx_line(rx_line), .cap_arm(cap_arm), .align(align),
        .stop(stop), .tx_mode(tx_mode), .tx_data(tx_data), .tx_load(tx_load),
        .tx_room(tx_room), .tx_line(tx_line), .rx_data(rx_data), .rx_full(rx_full),
        .rx_rd(rx_rd), .byte_strobe(byte_strobe), .overrun(overrun),
        .underrun(underrun), .cap_valid(cap_valid), .cap_time(cap_time)
    );

    // behavioural reference state
    int m_free, m_prev, m_armed, m_capv, m_capt, m_phase;
    int m_active, m_tx, m_rxcnt, m_rxbits, m_rxd, m_rxf, m_ovr;
    int m_pos, m_cur, m_sending, m_line, m_hold, m_holdf, m_und, m_strobe;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            m_free = 0; m_prev = 0; m_armed = 0; m_capv = 0; m_capt = 0; m_phase = 0;
            m_active = 0; m_tx = 0; m_rxcnt = 0; m_rxbits = 0; m_rxd = 0; m_rxf = 0;
            m_ovr = 0; m_pos = 0; m_cur = 0; m_sending = 0; m_line = 0; m_hold = 0;
            m_holdf = 0; m_und = 0; m_strobe = 0;
        end else begin
            int ph, capv_old, holdf_old, rxf_old;
            ph = m_phase; capv_old = m_capv; holdf_old = m_holdf; rxf_old = m_rxf;
            m_phase = (ph + 1) % 80;
            if (cap_arm) begin
                m_armed = 1; m_capv = 0;
            end else if (m_armed != 0 && int'(rx_line) != m_prev) begin
                m_armed = 0; m_capv = 1; m_capt = m_free; m_phase = 1;
            end
            m_prev = int'(rx_line);
            m_free = (m_free + 1) % 65536;
            m_strobe = 0;
            if (rx_rd) m_rxf = 0;
            if (tx_load && holdf_old == 0) begin m_hold = int'(tx_data); m_holdf = 1; end
            if (stop) begin
                m_active = 0; m_rxcnt = 0; m_pos = 0; m_sending = 0; m_line = 0;
            end else if (align && capv_old != 0) begin
                m_active = 1; m_tx = int'(tx_mode); m_rxcnt = 0; m_pos = 0;
                m_sending = 0; m_line = 0; m_ovr = 0; m_und = 0;
            end else if (m_active != 0) begin
                if (m_tx == 0 && ph == 40) begin
                    m_rxbits = ((m_rxbits << 1) | int'(rx_line)) & 255;
                    m_rxcnt++;
                    if (m_rxcnt == 8) begin
                        m_rxcnt = 0; m_rxd = m_rxbits; m_strobe = 1;
                        if (rxf_old != 0 && !rx_rd) m_ovr = 1;
                        m_rxf = 1;
                    end
                end
                if (m_tx != 0 && ph == 0) begin
                    if (m_pos == 0) begin
                        if (m_sending != 0) m_strobe = 1;
                        if (holdf_old != 0) begin
                            m_cur = m_hold; m_holdf = 0; m_sending = 1;
                            m_line = (m_cur >> 7) & 1; m_pos = 1;
                        end else begin
                            m_line = 0; m_sending = 0; m_und = 1;
                        end
                    end else begin
                        m_line = (m_cur >> (7 - m_pos)) & 1;
                        m_pos = (m_pos + 1) % 8;
                    end
                end
            end
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (run_cmp && !rst) begin
            chk(cap_valid === m_capv[0], "R2 cap_valid", int'(cap_valid), m_capv);
            chk(int'(cap_time) == m_capt, "R2 cap_time", int'(cap_time), m_capt);
            chk(tx_line === m_line[0], "R7 tx_line", int'(tx_line), m_line);
            chk(tx_room === !m_holdf[0], "R7 tx_room", int'(tx_room), 1 - m_holdf);
            chk(byte_strobe === m_strobe[0], "R8 byte_strobe", int'(byte_strobe), m_strobe);
            chk(int'(rx_data) == m_rxd, "R5 rx_data", int'(rx_data), m_rxd);
            chk(rx_full === m_rxf[0], "R6 rx_full", int'(rx_full), m_rxf);
            chk(overrun === m_ovr[0], "R6 overrun", int'(overrun), m_ovr);
            chk(underrun === m_und[0], "R9 underrun", int'(underrun), m_und);
            if (tx_line) seen_tx_high = 1'b1;
            if (byte_strobe) strobe_cnt++;
        end
    end

    always @(posedge clk) begin
        if (!done && cycles > 150000) begin
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cycles, 150000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic send_rx(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            rx_line = b[i];
            repeat (80) @(negedge clk);
        end
    endtask

    task automatic wait_strobe(input int exp, input string tag);
        int n = 0;
        while (!byte_strobe && n < 2000) begin @(negedge clk); n++; end
        chk(byte_strobe === 1'b1, {tag, " strobe seen"}, int'(byte_strobe), 1);
        chk(int'(rx_data) == exp, {tag, " rx_data"}, int'(rx_data), exp);
    endtask

    initial begin
        int exp_t, tx_bits, exp_bits, strobes0;
        repeat (3) @(negedge clk);
        rst = 1'b0; run_cmp = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!cap_valid && cap_time == 16'd0, "R1 capture cleared", int'(cap_valid), 0);
        chk(!tx_line && tx_room, "R1 tx idle with room", int'(tx_room), 1);
        chk(!rx_full && !overrun && !underrun, "R1 flags clear",
            int'({rx_full, overrun, underrun}), 0);

        // R4: align without capture is ignored; a preloaded byte stays put
        tx_data = 8'h5A; tx_load = 1'b1; @(negedge clk); tx_load = 1'b0;
        tx_mode = 1'b1; align = 1'b1; @(negedge clk); align = 1'b0;
        seen_tx_high = 1'b0;
        repeat (200) @(negedge clk);
        chk(!seen_tx_high && !tx_room && !underrun, "R4 align ignored",
            int'({seen_tx_high, tx_room, underrun}), 0);

        // R5/R6: receive four back-to-back bytes
        tx_mode = 1'b0;
        cap_arm = 1'b1; @(negedge clk); cap_arm = 1'b0;
        repeat (3) @(negedge clk);
        seen_tx_high = 1'b0;
        exp_t = m_free;
        fork
            begin
                send_rx(8'hA5); send_rx(8'h3C); send_rx(8'hF0); send_rx(8'h81);
            end
            begin
                repeat (10) @(negedge clk);
                chk(cap_valid === 1'b1, "R2 capture flag", int'(cap_valid), 1);
                chk(int'(cap_time) == exp_t, "R2 capture stamp", int'(cap_time), exp_t);
                align = 1'b1; @(negedge clk); align = 1'b0;
                wait_strobe(8'hA5, "R5 byte0");
                rx_rd = 1'b1; @(negedge clk); rx_rd = 1'b0;
                chk(!rx_full, "R6 read clears full", int'(rx_full), 0);
                @(negedge clk);
                wait_strobe(8'h3C, "R5 byte1");
                chk(!overrun, "R6 no overrun after read", int'(overrun), 0);
                @(negedge clk);
                wait_strobe(8'hF0, "R6 byte2");
                chk(overrun === 1'b1, "R6 overrun set", int'(overrun), 1);
                @(negedge clk);
                wait_strobe(8'h81, "R6 newer byte kept");
            end
        join
        chk(int'(cap_time) == exp_t, "R3 later edges ignored", int'(cap_time), exp_t);
        chk(!seen_tx_high, "R11 tx_line low in receive", int'(seen_tx_high), 0);

        // R10: stop, then line activity produces nothing
        stop = 1'b1; @(negedge clk); stop = 1'b0;
        strobes0 = strobe_cnt;
        for (int k = 0; k < 6; k++) begin rx_line = ~rx_line; repeat (50) @(negedge clk); end
        chk(strobe_cnt == strobes0, "R10 no sampling after stop", strobe_cnt, strobes0);

        // R3: arm and edge in the same cycle is not captured
        cap_arm = 1'b1; rx_line = ~rx_line; @(negedge clk); cap_arm = 1'b0;
        chk(cap_valid === 1'b0, "R3 arm clears valid", int'(cap_valid), 0);
        repeat (5) @(negedge clk);
        chk(cap_valid === 1'b0, "R3 coincident edge ignored", int'(cap_valid), 0);

        // R7/R8/R9: transmit; held 0x5A goes first, then 0xC6
        strobes0 = strobe_cnt;
        rx_line = ~rx_line;   // capture edge, negedge m_-1
        tx_mode = 1'b1;
        repeat (6) @(negedge clk);
        align = 1'b1; @(negedge clk); align = 1'b0;   // now at m_6
        tx_bits = 0;
        fork
            begin
                while (!tx_room) @(negedge clk);
                tx_data = 8'hC6; tx_load = 1'b1; @(negedge clk); tx_load = 1'b0;
            end
            begin
                repeat (114) @(negedge clk);          // reach m_120
                for (int k = 0; k < 16; k++) begin
                    tx_bits = (tx_bits << 1) | int'(tx_line);
                    if (k < 15) repeat (80) @(negedge clk);
                end
            end
        join
        exp_bits = 16'h5AC6;
        chk(tx_bits == exp_bits, "R7 serial bits MSB first", tx_bits, exp_bits);
        repeat (45) @(negedge clk);                   // past boundary at m_1360
        chk(underrun === 1'b1 && tx_line === 1'b0, "R9 underrun holds line low",
            int'({underrun, tx_line}), 2);
        chk(strobe_cnt - strobes0 == 2, "R8 strobe per byte", strobe_cnt - strobes0, 2);

        // R9 retry then R10 stop keeps line low
        tx_data = 8'hFF; tx_load = 1'b1; @(negedge clk); tx_load = 1'b0;
        stop = 1'b1; @(negedge clk); stop = 1'b0;
        seen_tx_high = 1'b0;
        repeat (400) @(negedge clk);
        chk(!seen_tx_high && !tx_room, "R10 idle after stop",
            int'({seen_tx_high, tx_room}), 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule